// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is a chain of 4-bit synchronous binary counter stages that together form one wider counter. All state bits change together on the rising clock edge. An active-low clear resets the whole chain at once, with no clock needed. An active-low load presets every stage from a parallel data word on the next edge. Two count enables control counting: a parallel enable that goes to every stage, and a carry enable. The carry enable feeds only the lowest stage, and it also gates that stage's carry output.

Each stage passes a ripple-carry to the stage above it. That carry is the stage's incoming carry enable ANDed with the condition "this nibble is at its maximum". The higher stage uses it as its own carry enable, so the chain counts modulo 16^STAGES with no glue logic. The carry out of the top stage is the terminal carry output. A wider counter can be built by feeding that output into the carry enable of another instance.

Top module: `bin_count_chain`

## Requirements
- R1: While clr_n is low the whole count is 0, from the moment it falls, whatever clk, load_n, en_p and en_t do; a load requested while clear is low is not taken.
- R2: When load_n is low at a rising edge, the count takes the value of din on that edge, whatever the levels of en_p and en_t.
- R3: When load_n, en_p and en_t are all high at a rising edge, the full count advances by one, modulo 16^STAGES (the maximum value wraps to 0).
- R4: When load_n is high and either en_p or en_t is low at a rising edge, the count holds its value.
- R5: tc is high exactly when en_t is high and every bit of the count is 1. It does not depend on en_p or load_n, and it follows en_t without waiting for a clock edge.
- R6: A stage above the lowest changes on a counting edge only if every stage below it reads 15 (4'hF) before that edge.
- R7: Stage k occupies count bits [4k+3:4k], so stage 0 is the least-significant nibble, and din is mapped onto the stages in the same way.
- R8: Starting from clear, loading 8'hFC and counting gives FD, FE, FF, 00, 01, 02. Then dropping an enable holds the count at 02, and tc is high only at FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Parallel count enable, routed to every stage |
| en_t | input | 1 | Carry count enable into the lowest stage |
| din | input | 4*STAGES | Parallel preset word |
| q | output | 4*STAGES | Concatenated count, stage 0 in the low nibble |
| tc | output | 1 | Terminal carry out of the top stage |

## Verification
Load and count can be requested on the same edge, and load must win. The bench provokes this by holding load_n low with both enables high, often while the low nibble sits at 15 so that a carry is also pending. It judges the result by comparing the count against din rather than against the incremented value. Clear and load can also overlap. Clear is driven low between edges while load is pending, and the count is required to read 0 both before and after the edge.

// File: rtl/bin_count_chain.sv
module bin_count_chain #(
  parameter int STAGES = 2,
  parameter int NIB_W  = 4,
  localparam int W = STAGES * NIB_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);

  logic [STAGES:0] carry_en;
  assign carry_en[0] = en_t;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [NIB_W-1:0] nib;
    logic             at_max;

    assign at_max        = &nib;
    assign carry_en[g+1] = carry_en[g] & at_max;
    assign q[g*NIB_W +: NIB_W] = nib;

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                   nib <= '0;
      else if (!load_n)             nib <= din[g*NIB_W +: NIB_W];
      else if (en_p && carry_en[g]) nib <= nib + 1'b1;
    end
  end

  assign tc = carry_en[STAGES];

  p_clear_zero_r1: assert property (@(posedge clk) !clr_n |-> q == '0);

  p_load_wins_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == $past(q) + 1'b1);

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  p_tc_full_r5: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> (q == '1 && en_t));

  if (STAGES > 1) begin : g_upper_chk
    p_upper_wait_r6: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && q[NIB_W-1:0] != '1) |=> $stable(q[W-1:NIB_W]));
  end

endmodule

// File: tb/bin_count_chain_tb.sv
`timescale 1ns/1ps
module bin_count_chain_tb;
  localparam int STAGES = 2;
  localparam int W = STAGES * 4;

  typedef struct {
    logic [W-1:0] q;
    logic         tc;
    logic         ld;
    logic         clr;
    string        tag;
  } exp_t;

  logic clk = 0;
  logic clr_n = 1;
  logic load_n = 1, en_p = 0, en_t = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic tc;

  exp_t sb[$];
  logic [W-1:0] model = '0;
  logic [W-1:0] prev_q = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bin_count_chain #(.STAGES(STAGES)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q), .tc(tc));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ld_n, input logic ep, input logic et,
                      input logic [W-1:0] d, input string tag);
    exp_t it;
    @(negedge clk);
    load_n = ld_n; en_p = ep; en_t = et; din = d;
    if (!ld_n) model = d;
    else if (ep && et) model = model + 1'b1;
    it.q = model; it.tc = et && (model == '1); it.ld = !ld_n; it.clr = 0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_clear();
    exp_t it;
    @(negedge clk);
    load_n = 0; en_p = 1; en_t = 1; din = W'($urandom);
    model = '0;
    it.q = '0; it.tc = 0; it.ld = 0; it.clr = 1; it.tag = "R1";
    sb.push_back(it);
    #0.5 clr_n = 0;
    #0.5 chk("R1 immediate", q, '0);
    @(negedge clk);
    clr_n = 1;
    load_n = 1; en_p = 0;
  endtask

  always @(posedge clk) begin
    exp_t it;
    #2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      chk(it.tag, q, it.q);
      chk({it.tag, " tc R5"}, W'(tc), W'(it.tc));
      if (!it.ld && !it.clr && prev_q[3:0] != 4'hF)
        chk("R6 upper waits", W'(q[W-1:4]), W'(prev_q[W-1:4]));
    end
    prev_q = q;
  end

  initial begin
    #1 clr_n = 0;
    #4;
    chk("R1 reset", q, '0);
    @(negedge clk) clr_n = 1;
    prev_q = '0;

    // R8 reference sequence
    step(0, 0, 0, 8'hFC, "R8 load");
    for (int i = 0; i < 6; i++) step(1, 1, 1, '0, "R8 count");
    step(1, 0, 1, '0, "R8 inhibit");
    step(1, 0, 1, '0, "R8 inhibit");

    // R7 nibble placement, R2 load over enables
    step(0, 1, 1, 8'h3A, "R7 R2 load");
    step(0, 0, 0, 8'hA3, "R7 R2 load");
    // R2 load beats pending carry
    step(0, 1, 1, 8'h4F, "R2");
    step(0, 1, 1, 8'h17, "R2 load over carry");
    // R4 each enable low alone
    step(1, 0, 1, '0, "R4 en_p low");
    step(1, 1, 0, '0, "R4 en_t low");
    // R5 tc ignores en_p, holds
    step(0, 0, 0, 8'hFF, "R5 load max");
    step(1, 0, 1, '0, "R5 tc with en_p low");
    step(1, 0, 0, '0, "R5 tc off");
    step(1, 1, 1, '0, "R3 wrap");
    // R6 carry into upper
    step(0, 0, 0, 8'h2E, "R6 load");
    for (int i = 0; i < 3; i++) step(1, 1, 1, '0, "R6 R3 carry");

    // R1 clear over pending load
    do_clear();

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 39) == 0) do_clear();
      else step($urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0,
                $urandom_range(0, 3) != 0, W'($urandom), "R3 random");
    end
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule